// File: doc/BRIEF.md
# EEPROM Write-Then-Read Test Sequencer

This controller runs a fixed test cycle on a byte-level I2C EEPROM engine clocked from the same source. On the system clock (45 MHz by default), it first keeps the engine in reset for a short time after its own reset is released. It then asserts an active-low write command for a fixed hold time. It waits out the EEPROM's internal programming interval, asserts an active-low read command for the same hold time, and then waits for the random-read transaction to finish. The address and data for these transactions are supplied to the engine from elsewhere.

The engine runs its SCL phase generator freely and samples its command inputs only at particular phases. Each command is therefore held for a whole number of SCL periods (two by default), so the engine cannot miss it. Every interval is a parameter derived from the clock frequency and the SCL divider, so a test can shorten them. When the read transaction time has passed, a one-cycle `done` pulse marks the moment a downstream serial stage can capture the read byte. A `start` pulse given while the block is idle runs the write/read cycle again without touching the engine reset. All pins are plain control and status signals, with no data stream and no back-pressure.

Top module: `eeprom_test_sequencer`

## Requirements
- R1: While `rst_n` is low, `eng_rst_n` is 0, `wr_cmd_n` and `rd_cmd_n` are 1, `done` is 0 and `busy` is 1.
- R2: After `rst_n` rises, `eng_rst_n` stays 0 for exactly RST_CYCLES clock edges and then stays 1 until the next system reset.
- R3: `wr_cmd_n` goes low on the same edge that releases `eng_rst_n`. It stays low for exactly SCL_DIV*HOLD_PERIODS cycles, then returns high.
- R4: `rd_cmd_n` goes low exactly GAP cycles after `wr_cmd_n` went low, where GAP = CLK_HZ/1e6*GAP_US (450,000 by default). It stays low for SCL_DIV*HOLD_PERIODS cycles.
- R5: `wr_cmd_n` and `rd_cmd_n` are never low in the same cycle.
- R6: `done` is high for exactly one cycle. That cycle begins SCL_DIV*RD_PERIODS cycles after `rd_cmd_n` went low.
- R7: `busy` is 1 from reset until `done` rises. It is 0 in the `done` cycle and while idle, and it returns to 1 in the first cycle of a restarted sequence.
- R8: A `start` sampled high while idle makes `wr_cmd_n` go low on that edge. The same R3/R4/R6 timing then applies, and `eng_rst_n` stays 1.
- R9: A `start` sampled high while `busy` is 1, or in the `done` cycle, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the I2C engine |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start | input | 1 | Request to rerun the write/read cycle while idle |
| eng_rst_n | output | 1 | Active-low reset to the I2C engine |
| wr_cmd_n | output | 1 | Active-low byte-write command |
| rd_cmd_n | output | 1 | Active-low random-read command |
| busy | output | 1 | High while a test cycle is in progress |
| done | output | 1 | One-cycle pulse when the read transaction time has elapsed |

## Verification
Every output is decoded from a single state register. Each result therefore appears on the very edge that crosses its boundary: the engine release and the write command come RST_CYCLES edges after reset release, and the read command comes GAP edges after the write command. `done` follows RD_CYCLES edges after the read command, and a restart takes effect on the edge that samples `start`. The bench counts edges from reset release, or from the edge that sampled `start`. It then compares every output in every cycle, at the falling edge, against a bench function of that edge count, so a result that arrives one cycle early or late is reported. Random start pulses during busy phases, including one in the `done` cycle, check that the timeline is unchanged.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  typedef enum logic [2:0] {
    ST_ENG_RST  = 3'd0,
    ST_WR_HOLD  = 3'd1,
    ST_PROG_GAP = 3'd2,
    ST_RD_HOLD  = 3'd3,
    ST_RD_WAIT  = 3'd4,
    ST_FIN      = 3'd5,
    ST_IDLE     = 3'd6
  } seq_state_t;
endpackage

// File: rtl/seq_cycle_timer.sv
module seq_cycle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] len,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = (cnt_q == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart || expire) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/seq_state_ctrl.sv
module seq_state_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int CW      = 8,
  parameter int RST_LEN = 4,
  parameter int WR_LEN  = 8,
  parameter int GAP_LEN = 32,
  parameter int RD_LEN  = 8,
  parameter int RW_LEN  = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          expire,
  output seq_state_t    state,
  output logic          restart,
  output logic [CW-1:0] len
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ENG_RST:  if (expire) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  if (expire) state_d = ST_PROG_GAP;
      ST_PROG_GAP: if (expire) state_d = ST_RD_HOLD;
      ST_RD_HOLD:  if (expire) state_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (expire) state_d = ST_FIN;
      ST_FIN:                  state_d = ST_IDLE;
      ST_IDLE:     if (start)  state_d = ST_WR_HOLD;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_ENG_RST:  len = CW'(RST_LEN);
      ST_WR_HOLD:  len = CW'(WR_LEN);
      ST_PROG_GAP: len = CW'(GAP_LEN);
      ST_RD_HOLD:  len = CW'(RD_LEN);
      ST_RD_WAIT:  len = CW'(RW_LEN);
      default:     len = CW'(1);
    endcase
  end

  assign restart = (state_d != state_q) || (state_q == ST_FIN) || (state_q == ST_IDLE);
  assign state   = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ENG_RST;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
  import eeprom_seq_pkg::*;
(
  input  seq_state_t state,
  output logic       eng_rst_n,
  output logic       wr_cmd_n,
  output logic       rd_cmd_n,
  output logic       busy,
  output logic       done
);
  always_comb begin
    eng_rst_n = (state != ST_ENG_RST);
    wr_cmd_n  = (state != ST_WR_HOLD);
    rd_cmd_n  = (state != ST_RD_HOLD);
    done      = (state == ST_FIN);
    busy      = (state != ST_FIN) && (state != ST_IDLE);
  end
endmodule

// File: rtl/eeprom_test_sequencer.sv
module eeprom_test_sequencer
  import eeprom_seq_pkg::*;
#(
  parameter int CLK_HZ       = 45_000_000,
  parameter int SCL_DIV      = 500,
  parameter int HOLD_PERIODS = 2,
  parameter int GAP_US       = 10_000,
  parameter int RD_PERIODS   = 39,
  parameter int RST_CYCLES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic eng_rst_n,
  output logic wr_cmd_n,
  output logic rd_cmd_n,
  output logic busy,
  output logic done
);
  localparam int HOLD_CYC = SCL_DIV * HOLD_PERIODS;
  localparam int GAP_CYC  = (CLK_HZ / 1_000_000) * GAP_US;
  localparam int RD_CYC   = SCL_DIV * RD_PERIODS;
  localparam int GAP_REST = GAP_CYC - HOLD_CYC;
  localparam int RD_REST  = RD_CYC - HOLD_CYC;
  localparam int MAX_A    = (GAP_REST > RD_REST) ? GAP_REST : RD_REST;
  localparam int MAX_B    = (HOLD_CYC > RST_CYCLES) ? HOLD_CYC : RST_CYCLES;
  localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(MAX_LEN + 1);

  seq_state_t  state;
  logic        restart;
  logic        expire;
  logic [CW-1:0] len;

  seq_state_ctrl #(
    .CW(CW), .RST_LEN(RST_CYCLES), .WR_LEN(HOLD_CYC),
    .GAP_LEN(GAP_REST), .RD_LEN(HOLD_CYC), .RW_LEN(RD_REST)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .expire(expire),
    .state(state), .restart(restart), .len(len)
  );

  seq_cycle_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .len(len), .expire(expire)
  );

  seq_out_decode u_dec (
    .state(state), .eng_rst_n(eng_rst_n), .wr_cmd_n(wr_cmd_n),
    .rd_cmd_n(rd_cmd_n), .busy(busy), .done(done)
  );
endmodule

// File: rtl/eeprom_test_sequencer_chk.sv
module eeprom_test_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic eng_rst_n,
  input logic wr_cmd_n,
  input logic rd_cmd_n,
  input logic busy,
  input logic done
);
  logic wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wr_seen <= 1'b0;
    else if (done)          wr_seen <= 1'b0;
    else if (!wr_cmd_n)     wr_seen <= 1'b1;
  end

  p_engrst_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst_n |=> eng_rst_n);

  p_rd_after_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_cmd_n) |-> wr_seen);

  p_cmd_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_cmd_n && !rd_cmd_n));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_low_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_wr_only_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_cmd_n) |-> ($past(!busy) || $past(!eng_rst_n)));
endmodule

bind eeprom_test_sequencer eeprom_test_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_rst_n(eng_rst_n), .wr_cmd_n(wr_cmd_n),
  .rd_cmd_n(rd_cmd_n), .busy(busy), .done(done)
);

// File: tb/sim_eeprom_test_sequencer.sv
module sim_eeprom_test_sequencer;
  localparam int CLK_HZ = 1_000_000;
  localparam int SDIV   = 4;
  localparam int HOLDP  = 2;
  localparam int GUS    = 40;
  localparam int RDP    = 39;
  localparam int RSTC   = 5;
  localparam int HOLD   = SDIV * HOLDP;
  localparam int GAP    = (CLK_HZ / 1_000_000) * GUS;
  localparam int RDC    = SDIV * RDP;
  localparam int LAST   = GAP + RDC;

  logic clk = 1'b0;
  logic rst_n, start;
  logic eng_rst_n, wr_cmd_n, rd_cmd_n, busy, done;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  eeprom_test_sequencer #(
    .CLK_HZ(CLK_HZ), .SCL_DIV(SDIV), .HOLD_PERIODS(HOLDP),
    .GAP_US(GUS), .RD_PERIODS(RDP), .RST_CYCLES(RSTC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .eng_rst_n(eng_rst_n),
    .wr_cmd_n(wr_cmd_n), .rd_cmd_n(rd_cmd_n), .busy(busy), .done(done)
  );

  function automatic logic exp_wr(int t);   return !(t >= 0 && t < HOLD); endfunction
  function automatic logic exp_rd(int t);   return !(t >= GAP && t < GAP + HOLD); endfunction
  function automatic logic exp_done(int t); return (t == LAST); endfunction
  function automatic logic exp_busy(int t); return (t < LAST); endfunction

  task automatic chk(string req, string sig, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, sig, cyc, act, exp);
    end
  endtask

  task automatic chk_all(string req, int t);
    chk(req, "eng_rst_n", eng_rst_n, 1'b1);
    chk({req, "/R3"}, "wr_cmd_n", wr_cmd_n, exp_wr(t));
    chk({req, "/R4"}, "rd_cmd_n", rd_cmd_n, exp_rd(t));
    chk({req, "/R6"}, "done", done, exp_done(t));
    chk({req, "/R7"}, "busy", busy, exp_busy(t));
  endtask

  // one test cycle from t=0 through some idle cycles; spurious starts per R9
  task automatic run_cycle(string req, int noise_pct, int idle_n);
    for (int t = 0; t <= LAST; t++) begin
      chk_all(req, t);
      if (t == LAST) start = 1'b1;                // R9 directed: start in done cycle
      else start = (($urandom % 100) < noise_pct);
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < idle_n; i++) begin
      chk_all({req, "/R9-idle"}, LAST + 1 + i);
      @(negedge clk);
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      cyc++;
      wd++;
      if (wd > 150000) begin
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "eng_rst_n", eng_rst_n, 1'b0);
    chk("R1", "wr_cmd_n", wr_cmd_n, 1'b1);
    chk("R1", "rd_cmd_n", rd_cmd_n, 1'b1);
    chk("R1", "done", done, 1'b0);
    chk("R1", "busy", busy, 1'b1);
    start = 1'b0;
    rst_n = 1'b1;
    // R2: engine reset held for RSTC edges
    for (int k = 0; k < RSTC; k++) begin
      chk("R2", "eng_rst_n", eng_rst_n, 1'b0);
      chk("R2", "wr_cmd_n", wr_cmd_n, 1'b1);
      chk("R7", "busy", busy, 1'b1);
      start = (k == 1);                          // R9: start during engine reset
      @(negedge clk);
      start = 1'b0;
    end
    // R2 R3 R4 R6 R7: first cycle after reset
    run_cycle("R2", 0, 6);
    // R8: restart from idle, then random start noise (R9) in later runs
    for (int r = 0; r < 5; r++) begin
      int idle_n = 1 + ($urandom % 12);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      run_cycle((r == 0) ? "R8" : "R9", (r == 0) ? 0 : 10 + r * 5, idle_n);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule